// File: doc/BRIEF.md
# Interleaved Memory Bank Address Decoder

This block sits in front of the bank controllers of a memory board built from two leaves of four DRAM banks each. For every incoming 40-bit physical address, it works out which of the eight banks, if any, owns that address. The answer arrives one clock later. It consists of a one-hot bank select, the byte offset of the address inside the selected bank, and flags for "nobody claims it", "a bank was misprogrammed for this address" and "more than one bank claimed it".

Each bank is described by four programmable fields:

- a 3-bit capacity code;
- a 32-bit base, which is the top 32 bits of a 40-bit address, so bases fall on 256-byte boundaries;
- a 3-bit interleave-ways code;
- a 4-bit slot number inside its interleave group.

A shared 8-bit bank-enable word gates the banks one by one. A 4-bit leaf-service mask gates whole leaves. All of these fields are loaded through a one-cycle register write port.

Banks of one group share a base and interleave on 256-byte blocks. A group covers capacity times ways bytes. Address bits starting at bit 8 pick the slot, and the bank whose programmed slot equals those bits owns the block.

Top module: `bank_addr_decoder`

## Requirements
- R1: After reset every bank reads as not installed, all banks are disabled and both leaves may service. A lookup then returns no hit, a zero bank select and no error flags.
- R2: Capacity code c gives these bank sizes: 0→16 MiB, 1→64 MiB, 2→128 MiB, 3 and 4→256 MiB, 5 and 6→1 GiB. A group spans the addresses from base×256 up to, but not including, base×256 plus the bank size times the number of ways.
- R3: A bank whose capacity code is 7 never claims an address, and raises no configuration error.
- R4: Ways code 0, 1, 2 or 3 means 1, 2, 4 or 8 ways, so log2 of the ways equals the code. Inside its range a bank claims only when address bits [8 +: code] equal its slot number.
- R5: When an address falls inside an enabled, installed bank's range, and that bank's slot is not below the way count or its ways code is 4–7, the bank does not claim. The response then carries the configuration-error flag.
- R6: The bank-enable word assigns its bits, from bit 0 upward, to leaf0 bank0, leaf0 bank1, leaf1 bank0, leaf1 bank1, leaf0 bank2, leaf0 bank3, leaf1 bank2 and leaf1 bank3. A clear bit stops that bank from claiming. Banks are numbered leaf×4 + bank, and the bank select uses this numbering.
- R7: Leaf-service mask bit L, for L = 0 or 1, must be 1 for any bank of leaf L to claim. Mask bits 3:2 have no effect.
- R8: Let r be the address minus base×256, and w the ways code. The reported offset is ((r >> (8+w)) << 8) | r[7:0], truncated to 30 bits.
- R9: When several banks claim the same address, the lowest-numbered bank wins. The response then carries a one-cycle multi-hit flag, and the bank select stays one-hot.
- R10: A request accepted on a clock edge produces its response on the next edge. Outside a response, the select and all flags are zero. A response with no claimant sets the no-hit flag.
- R11: Config writes take effect on the next edge. Address 0x00 loads the enable word from data[7:0]. Address 0x01 loads the leaf mask from data[3:0]. Address 0x20 | bank<<2 | field loads one bank field: field 0 is the capacity code, 1 the base, 2 the ways code and 3 the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 40 | Physical address to decode |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 8 | One-hot select of the claiming bank |
| rsp_offset | output | 30 | Byte offset inside the claiming bank |
| rsp_nohit | output | 1 | No bank claimed the address |
| rsp_cfg_err | output | 1 | A range-matching bank had an illegal slot or ways code |
| rsp_multi | output | 1 | More than one bank claimed the address |

## Verification
The decoder is tried with addresses at both ends of each group range and one byte past the end, and with addresses that alternate between interleave slots. These cases separate an off-by-one range bound from a wrong slot field. Programming a 2-way, 4-way, 8-way and 1-way group shows whether the slot width and the offset shift follow the ways code. Two overlapping banks check the priority order and the multi-hit flag. Enabling a single bit of the enable word, and clearing single leaf-mask bits, shows that the enable-bit ordering and the leaf gating reach the right banks. An uninstalled bank and an out-of-range slot separate silent exclusion from an error report.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  localparam int ADDR_W = 40;
  localparam int BASE_W = 32;
  localparam int BLK_LG = ADDR_W - BASE_W;
  localparam int OFF_W  = 30;
  localparam int SIZE_W = 3;
  localparam int WAYS_W = 3;
  localparam int POS_W  = 4;

  localparam logic [SIZE_W-1:0] SIZE_ABSENT = 3'd7;

  typedef enum logic [1:0] {
    FLD_SIZE = 2'd0,
    FLD_BASE = 2'd1,
    FLD_WAYS = 2'd2,
    FLD_POS  = 2'd3
  } bank_field_e;

  // log2 of the bank capacity in bytes
  function automatic int unsigned size_lg(input logic [SIZE_W-1:0] code);
    case (code)
      3'd0:         return 24;
      3'd1:         return 26;
      3'd2:         return 27;
      3'd3, 3'd4:   return 28;
      3'd5, 3'd6:   return 30;
      default:      return 0;
    endcase
  endfunction

  function automatic logic ways_legal(input logic [WAYS_W-1:0] code);
    return code <= 3'd3;
  endfunction

  function automatic int unsigned ways_lg(input logic [WAYS_W-1:0] code);
    return int'(code[1:0]);
  endfunction

  // bit of the shared enable word that gates bank b of a given leaf
  function automatic int unsigned en_bit(input int leaf, input int b, input int nleaf);
    return (b / 2) * (2 * nleaf) + leaf * 2 + (b % 2);
  endfunction

  // bank-local byte offset: drop the slot bits above the 256-byte block
  function automatic logic [OFF_W-1:0] local_off(input logic [ADDR_W-1:0] rel,
                                                 input int unsigned wl);
    logic [ADDR_W-1:0] t;
    t = ((rel >> (BLK_LG + wl)) << BLK_LG) | (rel & ADDR_W'(255));
    return t[OFF_W-1:0];
  endfunction

endpackage

// File: rtl/mbd_cfg_regs.sv
module mbd_cfg_regs
  import mbd_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int LEAF_MASK_W = 4,
  parameter int CFG_AW      = 6,
  parameter int DATA_W      = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [CFG_AW-1:0]                  cfg_addr,
  input  logic [DATA_W-1:0]                  cfg_wdata,
  output logic [NUM_BANKS-1:0]               bank_en,
  output logic [LEAF_MASK_W-1:0]             leaf_mask,
  output logic [NUM_BANKS-1:0][SIZE_W-1:0]   size_code,
  output logic [NUM_BANKS-1:0][BASE_W-1:0]   base_reg,
  output logic [NUM_BANKS-1:0][WAYS_W-1:0]   ways_code,
  output logic [NUM_BANKS-1:0][POS_W-1:0]    slot_reg
);

  localparam int IDX_W = CFG_AW - 3;

  logic              bank_space;
  logic [IDX_W-1:0]  bank_idx;
  bank_field_e       fld;

  assign bank_space = cfg_addr[CFG_AW-1];
  assign bank_idx   = cfg_addr[CFG_AW-2:2];
  assign fld        = bank_field_e'(cfg_addr[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_en   <= '0;
      leaf_mask <= '1;
      for (int i = 0; i < NUM_BANKS; i++) begin
        size_code[i] <= SIZE_ABSENT;
        base_reg[i]  <= '0;
        ways_code[i] <= '0;
        slot_reg[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (bank_space) begin
        case (fld)
          FLD_SIZE: size_code[bank_idx] <= cfg_wdata[SIZE_W-1:0];
          FLD_BASE: base_reg[bank_idx]  <= cfg_wdata[BASE_W-1:0];
          FLD_WAYS: ways_code[bank_idx] <= cfg_wdata[WAYS_W-1:0];
          default:  slot_reg[bank_idx]  <= cfg_wdata[POS_W-1:0];
        endcase
      end else if (cfg_addr[0]) begin
        leaf_mask <= cfg_wdata[LEAF_MASK_W-1:0];
      end else begin
        bank_en <= cfg_wdata[NUM_BANKS-1:0];
      end
    end
  end

  // R11: a write strobe with a global address leaves every bank field unchanged
  a_r11_global_keeps_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !bank_space) |=> ($stable(size_code) && $stable(base_reg)
                                 && $stable(ways_code) && $stable(slot_reg)));

endmodule

// File: rtl/mbd_bank_match.sv
module mbd_bank_match
  import mbd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 bank_on,
  input  logic                 leaf_on,
  input  logic [SIZE_W-1:0]    size_code,
  input  logic [BASE_W-1:0]    base,
  input  logic [WAYS_W-1:0]    ways_code,
  input  logic [POS_W-1:0]     slot,
  output logic                 claim,
  output logic                 cfg_bad,
  output logic [OFF_W-1:0]     offset
);

  logic [ADDR_W:0]    diff;
  logic [ADDR_W-1:0]  rel;
  logic [ADDR_W-1:0]  slot_mask;
  logic [ADDR_W-1:0]  addr_slot;
  int unsigned        wl;
  int unsigned        span_lg;
  logic               installed;
  logic               eligible;
  logic               in_range;
  logic               slot_ok;
  logic               slot_match;

  always_comb begin
    wl         = ways_lg(ways_code);
    span_lg    = size_lg(size_code) + wl;
    diff       = {1'b0, req_addr} - {1'b0, base, {BLK_LG{1'b0}}};
    rel        = diff[ADDR_W-1:0];
    in_range   = !diff[ADDR_W] && ((rel >> span_lg) == '0);
    installed  = size_code != SIZE_ABSENT;
    eligible   = bank_on && leaf_on && installed;
    slot_mask  = (ADDR_W'(1) << wl) - ADDR_W'(1);
    addr_slot  = (req_addr >> BLK_LG) & slot_mask;
    slot_ok    = ways_legal(ways_code) && (ADDR_W'(slot) <= slot_mask);
    slot_match = addr_slot == ADDR_W'(slot);
    claim      = eligible && in_range && slot_ok && slot_match;
    cfg_bad    = eligible && in_range && !slot_ok;
    offset     = local_off(rel, wl);
  end

  a_r3_absent_never_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == SIZE_ABSENT) |-> (!claim && !cfg_bad));

  a_r5_bad_slot_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> !claim);

  a_r6_disabled_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_on |-> !claim);

  a_r7_leaf_off_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !leaf_on |-> !claim);

endmodule

// File: rtl/mbd_hit_select.sv
module mbd_hit_select
  import mbd_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic [NUM_BANKS-1:0]              claim,
  input  logic [NUM_BANKS-1:0]              cfg_bad,
  input  logic [NUM_BANKS-1:0][OFF_W-1:0]   offs,
  output logic                              rsp_valid,
  output logic [NUM_BANKS-1:0]              rsp_hit,
  output logic [OFF_W-1:0]                  rsp_offset,
  output logic                              rsp_nohit,
  output logic                              rsp_cfg_err,
  output logic                              rsp_multi
);

  logic [NUM_BANKS-1:0] win;
  logic [OFF_W-1:0]     win_off;
  logic                 several;

  always_comb begin
    win     = '0;
    win_off = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (claim[i]) begin
        win     = '0;
        win[i]  = 1'b1;
        win_off = offs[i];
      end
    end
    several = $countones(claim) > 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= '0;
      rsp_offset  <= '0;
      rsp_nohit   <= 1'b0;
      rsp_cfg_err <= 1'b0;
      rsp_multi   <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= req_valid ? win : '0;
      rsp_offset  <= req_valid ? win_off : '0;
      rsp_nohit   <= req_valid && (claim == '0);
      rsp_cfg_err <= req_valid && (cfg_bad != '0);
      rsp_multi   <= req_valid && several;
    end
  end

  a_r9_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_hit));

  a_r9_multi_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> (rsp_hit != '0));

  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && claim[0]) |=> rsp_hit[0]);

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_hit == '0 && !rsp_nohit && !rsp_cfg_err && !rsp_multi));

  a_r10_nohit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nohit |-> (rsp_hit == '0 && rsp_valid));

endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import mbd_pkg::*;
#(
  parameter int NUM_LEAVES     = 2,
  parameter int BANKS_PER_LEAF = 4,
  parameter int LEAF_MASK_W    = 4,
  parameter int DATA_W         = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [2+$clog2(NUM_LEAVES*BANKS_PER_LEAF):0] cfg_addr,
  input  logic [DATA_W-1:0]                    cfg_wdata,
  input  logic                                 req_valid,
  input  logic [ADDR_W-1:0]                    req_addr,
  output logic                                 rsp_valid,
  output logic [NUM_LEAVES*BANKS_PER_LEAF-1:0] rsp_hit,
  output logic [OFF_W-1:0]                     rsp_offset,
  output logic                                 rsp_nohit,
  output logic                                 rsp_cfg_err,
  output logic                                 rsp_multi
);

  localparam int NUM_BANKS = NUM_LEAVES * BANKS_PER_LEAF;
  localparam int CFG_AW    = 3 + $clog2(NUM_BANKS);

  logic [NUM_BANKS-1:0]               bank_en;
  logic [LEAF_MASK_W-1:0]             leaf_mask;
  logic [NUM_BANKS-1:0][SIZE_W-1:0]   size_code;
  logic [NUM_BANKS-1:0][BASE_W-1:0]   base_reg;
  logic [NUM_BANKS-1:0][WAYS_W-1:0]   ways_code;
  logic [NUM_BANKS-1:0][POS_W-1:0]    slot_reg;
  logic [NUM_BANKS-1:0]               claim;
  logic [NUM_BANKS-1:0]               cfg_bad;
  logic [NUM_BANKS-1:0][OFF_W-1:0]    offs;

  mbd_cfg_regs #(
    .NUM_BANKS   (NUM_BANKS),
    .LEAF_MASK_W (LEAF_MASK_W),
    .CFG_AW      (CFG_AW),
    .DATA_W      (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .bank_en   (bank_en),
    .leaf_mask (leaf_mask),
    .size_code (size_code),
    .base_reg  (base_reg),
    .ways_code (ways_code),
    .slot_reg  (slot_reg)
  );

  for (genvar lf = 0; lf < NUM_LEAVES; lf++) begin : g_leaf
    for (genvar b = 0; b < BANKS_PER_LEAF; b++) begin : g_bank
      localparam int IDX = lf * BANKS_PER_LEAF + b;
      localparam int EB  = en_bit(lf, b, NUM_LEAVES);
      mbd_bank_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_addr  (req_addr),
        .bank_on   (bank_en[EB]),
        .leaf_on   (leaf_mask[lf]),
        .size_code (size_code[IDX]),
        .base      (base_reg[IDX]),
        .ways_code (ways_code[IDX]),
        .slot      (slot_reg[IDX]),
        .claim     (claim[IDX]),
        .cfg_bad   (cfg_bad[IDX]),
        .offset    (offs[IDX])
      );
    end
  end

  mbd_hit_select #(
    .NUM_BANKS (NUM_BANKS)
  ) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .claim       (claim),
    .cfg_bad     (cfg_bad),
    .offs        (offs),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_offset  (rsp_offset),
    .rsp_nohit   (rsp_nohit),
    .rsp_cfg_err (rsp_cfg_err),
    .rsp_multi   (rsp_multi)
  );

  // R1: the cycle after reset no bank is enabled, so no claim can exist
  a_r1_reset_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (claim == '0));

endmodule

// File: tb/bank_addr_decoder_tb.sv
`timescale 1ns/1ps
module bank_addr_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [39:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_hit;
  logic [29:0] rsp_offset;
  logic        rsp_nohit;
  logic        rsp_cfg_err;
  logic        rsp_multi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bank_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_offset(rsp_offset),
    .rsp_nohit(rsp_nohit), .rsp_cfg_err(rsp_cfg_err), .rsp_multi(rsp_multi)
  );

  typedef struct packed {
    logic [39:0] a;
    logic [7:0]  h;
    logic [29:0] o;
    logic        n;
    logic        c;
    logic        m;
    logic [7:0]  r;
  } vec_t;

  // bank0/1: 16 MiB, 2-way at 0; bank4: 64 MiB at 4 GiB; bank2 absent at 8 GiB;
  // bank3: 4-way slot 5 at 12 GiB; bank5 1 GiB and bank6 16 MiB both at 16 GiB
  localparam vec_t VT [13] = '{
    '{40'h00_0000_0000, 8'h01, 30'h0000000, 1'b0, 1'b0, 1'b0, 8'd4}, // R4 slot 0
    '{40'h00_0000_0100, 8'h02, 30'h0000000, 1'b0, 1'b0, 1'b0, 8'd4}, // R4 slot 1
    '{40'h00_0000_0234, 8'h01, 30'h0000134, 1'b0, 1'b0, 1'b0, 8'd8}, // R8
    '{40'h00_01FF_FFFF, 8'h02, 30'h0FFFFFF, 1'b0, 1'b0, 1'b0, 8'd2}, // R2 top byte
    '{40'h00_0200_0000, 8'h00, 30'h0000000, 1'b1, 1'b0, 1'b0, 8'd2}, // R2 one past
    '{40'h01_0000_0000, 8'h10, 30'h0000000, 1'b0, 1'b0, 1'b0, 8'd2}, // R2 base
    '{40'h01_03FF_FFFF, 8'h10, 30'h3FFFFFF, 1'b0, 1'b0, 1'b0, 8'd2}, // R2 64 MiB end
    '{40'h01_0400_0000, 8'h00, 30'h0000000, 1'b1, 1'b0, 1'b0, 8'd10},// R10 nohit
    '{40'h02_0000_0000, 8'h00, 30'h0000000, 1'b1, 1'b0, 1'b0, 8'd3}, // R3 absent
    '{40'h03_0000_0100, 8'h00, 30'h0000000, 1'b1, 1'b1, 1'b0, 8'd5}, // R5 bad slot
    '{40'h04_0000_0100, 8'h20, 30'h0000100, 1'b0, 1'b0, 1'b1, 8'd9}, // R9 overlap
    '{40'h04_0200_0000, 8'h20, 30'h2000000, 1'b0, 1'b0, 1'b0, 8'd9}, // R9 single
    '{40'h00_FFFF_FFFF, 8'h00, 30'h0000000, 1'b1, 1'b0, 1'b0, 8'd10} // R10 gap
  };

  task automatic check(input int req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // R11 register map: 0x00 enables, 0x01 leaf mask, 0x20|bank<<2|field
  task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bank_wr(input int bank, input logic [2:0] sz, input logic [31:0] base,
                         input logic [2:0] wc, input logic [3:0] pos);
    cfg_wr(6'h20 | 6'(bank << 2) | 6'd0, 32'(sz));
    cfg_wr(6'h20 | 6'(bank << 2) | 6'd1, base);
    cfg_wr(6'h20 | 6'(bank << 2) | 6'd2, 32'(wc));
    cfg_wr(6'h20 | 6'(bank << 2) | 6'd3, 32'(pos));
  endtask

  task automatic lookup(input logic [39:0] a, input logic [7:0] eh, input logic [29:0] eo,
                        input logic en, input logic ec, input logic em, input int req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(10, "valid", 64'(rsp_valid), 64'd1);
    check(req, "hit", 64'(rsp_hit), 64'(eh));
    check(req, "offset", 64'(rsp_offset), 64'(eo));
    check(req, "nohit", 64'(rsp_nohit), 64'(en));
    check(req, "cfg_err", 64'(rsp_cfg_err), 64'(ec));
    check(req, "multi", 64'(rsp_multi), 64'(em));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R10 watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10: idle outputs, then a lookup after reset misses
    check(10, "idle valid", 64'(rsp_valid), 64'd0);
    check(1, "idle hit", 64'(rsp_hit), 64'd0);
    lookup(40'h0, 8'h00, 30'h0, 1'b1, 1'b0, 1'b0, 1);

    bank_wr(0, 3'd0, 32'h0000_0000, 3'd1, 4'd0);
    bank_wr(1, 3'd0, 32'h0000_0000, 3'd1, 4'd1);
    bank_wr(4, 3'd1, 32'h0100_0000, 3'd0, 4'd0);
    bank_wr(2, 3'd7, 32'h0200_0000, 3'd0, 4'd0);
    bank_wr(3, 3'd0, 32'h0300_0000, 3'd2, 4'd5);
    bank_wr(5, 3'd5, 32'h0400_0000, 3'd0, 4'd0);
    bank_wr(6, 3'd0, 32'h0400_0000, 3'd0, 4'd0);
    // R1: still all disabled after programming fields
    lookup(40'h0, 8'h00, 30'h0, 1'b1, 1'b0, 1'b0, 1);
    cfg_wr(6'h00, 32'hFF);

    for (int i = 0; i < 13; i++)
      lookup(VT[i].a, VT[i].h, VT[i].o, VT[i].n, VT[i].c, VT[i].m, int'(VT[i].r));

    // R6: only enable bit 2 set -> leaf1 bank0 (index 4) alone
    cfg_wr(6'h00, 32'h04);
    lookup(40'h01_0000_0010, 8'h10, 30'h10, 1'b0, 1'b0, 1'b0, 6);
    lookup(40'h00_0000_0000, 8'h00, 30'h0, 1'b1, 1'b0, 1'b0, 6);
    // R6: bit 4 -> leaf0 bank2 region; bank2 absent so use bit 5 (leaf0 bank3)
    cfg_wr(6'h00, 32'h20);
    lookup(40'h03_0000_0100, 8'h00, 30'h0, 1'b1, 1'b1, 1'b0, 6);

    // R7: leaf mask gating, upper bits ignored
    cfg_wr(6'h00, 32'hFF);
    cfg_wr(6'h01, 32'hE);
    lookup(40'h00_0000_0000, 8'h00, 30'h0, 1'b1, 1'b0, 1'b0, 7);
    lookup(40'h01_0000_0000, 8'h10, 30'h0, 1'b0, 1'b0, 1'b0, 7);
    cfg_wr(6'h01, 32'h1);
    lookup(40'h01_0000_0000, 8'h00, 30'h0, 1'b1, 1'b0, 1'b0, 7);
    lookup(40'h00_0000_0100, 8'h02, 30'h0, 1'b0, 1'b0, 1'b0, 7);
    cfg_wr(6'h01, 32'h3);
    lookup(40'h01_0000_0000, 8'h10, 30'h0, 1'b0, 1'b0, 1'b0, 7);

    // R4 / R8: 8-way group, bank0 alone, slot 5
    cfg_wr(6'h00, 32'h01);
    bank_wr(0, 3'd0, 32'h0000_0000, 3'd3, 4'd5);
    lookup(40'h00_0000_0500, 8'h01, 30'h000, 1'b0, 1'b0, 1'b0, 4);
    lookup(40'h00_0000_0D23, 8'h01, 30'h123, 1'b0, 1'b0, 1'b0, 8);
    lookup(40'h00_0000_0600, 8'h00, 30'h0, 1'b1, 1'b0, 1'b0, 4);
    // R5: ways code 5 is illegal
    cfg_wr(6'h28 - 6'h08 + 6'h02, 32'd5);
    lookup(40'h00_0000_0500, 8'h00, 30'h0, 1'b1, 1'b1, 1'b0, 5);
    // R2: capacity code 2 (128 MiB), 1-way
    bank_wr(0, 3'd2, 32'h0000_0000, 3'd0, 4'd0);
    lookup(40'h00_07FF_FFFF, 8'h01, 30'h7FFFFFF, 1'b0, 1'b0, 1'b0, 2);
    lookup(40'h00_0800_0000, 8'h00, 30'h0, 1'b1, 1'b0, 1'b0, 2);
    // R3: code 7 removes the bank
    cfg_wr(6'h20, 32'd7);
    lookup(40'h00_0000_0000, 8'h00, 30'h0, 1'b1, 1'b0, 1'b0, 3);
    // R11: global write leaves bank fields; re-install and read back via lookup
    cfg_wr(6'h20, 32'd0);
    cfg_wr(6'h01, 32'hF);
    lookup(40'h00_0000_0042, 8'h01, 30'h42, 1'b0, 1'b0, 1'b0, 11);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule